// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch status of every hardware thread in a multithreaded front end. Each thread has its own state machine and four sticky stall flags, one for each downstream stage (decode, rename, execute, commit). In each cycle the controller takes block and unblock pulses from those stages, squash requests from commit and from decode, a flag that says the reorder buffer is still squashing, and a global context-switch flag. It settles these in a fixed priority order, then handles instruction-cache traffic: it issues requests, accepts or drops responses, and handles refusal and retry.

One retry slot is shared by the whole stage. A thread whose cache request is refused takes the slot and raises a global cache-blocked flag, and a later retry pulse serves that thread. Every squash advances the thread's request tag, so a response that was in flight at the time arrives with a stale tag and is thrown away. The controller counts each dropped response. PC generation, branch prediction and instruction extraction are left to neighbouring logic, which reads `status_o` and `req_tag_o`.

Top module: `fetch_status_ctl`

## Requirements
- R1: A block pulse on `block_i[t][s]` sets stall flag s of thread t, and an unblock pulse without a block pulse clears it. The result shows on `stall_bits_o` after the clock edge. The flag order is bit 0 decode, bit 1 rename, bit 2 execute, bit 3 commit.
- R2: In the cycle after an unblock pulse arrives for a flag that is already clear, or arrives together with a block pulse for the same flag, `protocol_err_o` is high for one cycle. The illegal unblock leaves the flag clear.
- R3: A commit squash moves the thread to Squashing (encoding 2) and increments its request tag; it overrides every other event. Otherwise, reorder-buffer-squashing moves the thread to Squashing and leaves the tag unchanged.
- R4: A decode squash on a thread that is not in Squashing moves it to Squashing and increments its tag. On a thread already in Squashing it has no effect.
- R5: A thread is stalled when any of its updated stall flags is set or `ctx_switch_i` is high. If no squash applies, a stalled thread goes to Blocked (3). A thread in WaitResponse (4) or WaitRetry (5) is exempt.
- R6: If no squash and no stall applies, a thread in Blocked or Squashing returns to Running (1).
- R7: A request (`req_valid_i`, `req_tid_i`) on a quiet thread in Running, with cache-blocked clear and `req_grant_i` high, moves the thread to WaitResponse. A request on a thread in LineReady (6) moves it to Running. Requests in any other case are ignored.
- R8: A response is accepted only if its thread is in WaitResponse, had no squash in that cycle, and `rsp_tag_i` equals the thread's `req_tag_o`. Every other response increments `drop_cnt_o`.
- R9: An accepted response moves the thread to Blocked if the thread is stalled, and to LineReady if it is not.
- R10: A refused request (`req_grant_i` low) moves the thread to WaitRetry, fills the retry slot with the thread number and sets `cache_blocked_o`. A retry pulse clears `cache_blocked_o` and the slot, and moves the slot's owner to WaitResponse. A retry pulse with an empty slot changes nothing except `cache_blocked_o`.
- R11: A squash of the thread that owns the retry slot empties the slot and clears `cache_blocked_o`. A squash of any other thread leaves both as they are.
- R12: After reset every thread is in Running with all stall flags clear and tag 0, the slot is empty, cache-blocked is clear and the drop count is 0. The encodings Idle (0), TrapPending (7) and QuiescePending (8) are reserved and are never entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| block_i | input | NUM_THREADS x 4 | Per-thread, per-stage block pulses |
| unblock_i | input | NUM_THREADS x 4 | Per-thread, per-stage unblock pulses |
| cmt_squash_i | input | NUM_THREADS | Squash request from commit |
| rob_squashing_i | input | NUM_THREADS | Reorder buffer still squashing |
| dec_squash_i | input | NUM_THREADS | Squash request from decode |
| ctx_switch_i | input | 1 | Global context-switch stall |
| req_valid_i | input | 1 | Fetch attempt for thread `req_tid_i` |
| req_tid_i | input | TID_W | Thread of the fetch attempt |
| req_grant_i | input | 1 | Cache accepts the request this cycle |
| rsp_valid_i | input | 1 | Cache response valid |
| rsp_tid_i | input | TID_W | Thread of the response |
| rsp_tag_i | input | TAG_W | Tag carried by the response |
| retry_i | input | 1 | Cache retry pulse |
| status_o | output | NUM_THREADS x 4 | Per-thread state encoding |
| stall_bits_o | output | NUM_THREADS x 4 | Per-thread stall flags |
| req_tag_o | output | NUM_THREADS x TAG_W | Current request tag per thread |
| cache_blocked_o | output | 1 | Cache-blocked flag |
| retry_valid_o | output | 1 | Retry slot occupied |
| retry_tid_o | output | TID_W | Owner of the retry slot |
| drop_cnt_o | output | CNT_W | Count of discarded responses |
| protocol_err_o | output | 1 | Illegal unblock seen last cycle |

## Verification
The central collision is a cache response that arrives in the same cycle as a squash of its own thread. The response carries the old tag while the squash advances it, so the response must be dropped and counted, and the thread must still end in Squashing. The bench provokes this by driving a commit squash together with a tag-matching response for a thread in WaitResponse. It then checks the state, the new tag and the drop count. A second overlap is a squash on a thread that is not the retry owner while the slot is occupied; the bench checks that the slot and cache-blocked survive that squash.

// File: rtl/fsc_pkg.sv
`timescale 1ns/1ps
package fsc_pkg;
  // Per-thread fetch state encoding, 4 bits wide.
  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_RUN        = 4'd1,
    ST_SQUASH     = 4'd2,
    ST_BLOCK      = 4'd3,
    ST_WAIT_RSP   = 4'd4,
    ST_WAIT_RETRY = 4'd5,
    ST_LINE_READY = 4'd6,
    ST_TRAP       = 4'd7,
    ST_QUIESCE    = 4'd8
  } fstat_e;

  localparam int NUM_STAGES = 4;
endpackage

// File: rtl/fsc_stall_bits.sv
`timescale 1ns/1ps
module fsc_stall_bits #(
  parameter int NUM_THREADS = 2
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [NUM_THREADS-1:0][fsc_pkg::NUM_STAGES-1:0] block_i,
  input  logic [NUM_THREADS-1:0][fsc_pkg::NUM_STAGES-1:0] unblock_i,
  output logic [NUM_THREADS-1:0][fsc_pkg::NUM_STAGES-1:0] bits_q,
  output logic [NUM_THREADS-1:0][fsc_pkg::NUM_STAGES-1:0] bits_next,
  output logic                                          err_q
);
  logic err_d;

  always_comb begin
    bits_next = block_i | (bits_q & ~unblock_i);
    err_d     = |(unblock_i & (~bits_q | block_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      err_q  <= 1'b0;
    end else begin
      bits_q <= bits_next;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/fsc_thread_fsm.sv
`timescale 1ns/1ps
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stalled_i,
  input  logic             cmt_sq_i,
  input  logic             rob_sq_i,
  input  logic             dec_sq_i,
  input  logic             rsp_hit_i,
  input  logic [TAG_W-1:0] rsp_tag_i,
  input  logic             retry_own_i,
  input  logic             req_i,
  input  logic             grant_i,
  input  logic             cache_blocked_i,
  output fstat_e           state_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             kill_o,
  output logic             refuse_o,
  output logic             rsp_take_o
);
  fstat_e           state_q, state_d;
  logic [TAG_W-1:0] tag_q;
  logic             quiet;

  always_comb begin
    state_d    = state_q;
    kill_o     = 1'b0;
    quiet      = 1'b0;
    refuse_o   = 1'b0;
    // Control phase: squashes and stalls, highest priority first.
    if (cmt_sq_i) begin
      state_d = ST_SQUASH;
      kill_o  = 1'b1;
    end else if (rob_sq_i) begin
      state_d = ST_SQUASH;
    end else if (dec_sq_i && state_q != ST_SQUASH) begin
      state_d = ST_SQUASH;
      kill_o  = 1'b1;
    end else if (stalled_i && state_q != ST_WAIT_RSP && state_q != ST_WAIT_RETRY) begin
      state_d = ST_BLOCK;
    end else if (state_q == ST_BLOCK || state_q == ST_SQUASH) begin
      state_d = ST_RUN;
    end else begin
      quiet = 1'b1;
    end

    rsp_take_o = quiet && rsp_hit_i && state_q == ST_WAIT_RSP && rsp_tag_i == tag_q;

    // Cache phase: only for a thread the control phase left alone.
    if (quiet) begin
      if (rsp_take_o) begin
        state_d = stalled_i ? ST_BLOCK : ST_LINE_READY;
      end else if (retry_own_i && state_q == ST_WAIT_RETRY) begin
        state_d = ST_WAIT_RSP;
      end else if (req_i) begin
        if (state_q == ST_LINE_READY) begin
          state_d = ST_RUN;
        end else if (state_q == ST_RUN && !cache_blocked_i) begin
          if (grant_i) begin
            state_d = ST_WAIT_RSP;
          end else begin
            state_d  = ST_WAIT_RETRY;
            refuse_o = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      if (kill_o) tag_q <= tag_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign tag_o   = tag_q;
endmodule

// File: rtl/fsc_retry_slot.sv
`timescale 1ns/1ps
module fsc_retry_slot #(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] refuse_vec_i,
  input  logic [NUM_THREADS-1:0] kill_vec_i,
  input  logic                   retry_i,
  output logic                   valid_o,
  output logic [TID_W-1:0]       tid_o,
  output logic                   blocked_o
);
  logic [TID_W-1:0] new_tid;

  always_comb begin
    new_tid = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (refuse_vec_i[i]) new_tid = TID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      tid_o     <= '0;
      blocked_o <= 1'b0;
    end else begin
      if (retry_i) begin
        valid_o   <= 1'b0;
        blocked_o <= 1'b0;
      end else if (valid_o && kill_vec_i[tid_o]) begin
        valid_o   <= 1'b0;
        blocked_o <= 1'b0;
      end
      if (|refuse_vec_i) begin
        valid_o   <= 1'b1;
        tid_o     <= new_tid;
        blocked_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fetch_status_ctl.sv
`timescale 1ns/1ps
module fetch_status_ctl
  import fsc_pkg::*;
#(
  parameter  int NUM_THREADS = 2,
  parameter  int TAG_W       = 3,
  parameter  int CNT_W       = 8,
  localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_THREADS-1:0][NUM_STAGES-1:0] block_i,
  input  logic [NUM_THREADS-1:0][NUM_STAGES-1:0] unblock_i,
  input  logic [NUM_THREADS-1:0]                cmt_squash_i,
  input  logic [NUM_THREADS-1:0]                rob_squashing_i,
  input  logic [NUM_THREADS-1:0]                dec_squash_i,
  input  logic                                  ctx_switch_i,
  input  logic                                  req_valid_i,
  input  logic [TID_W-1:0]                      req_tid_i,
  input  logic                                  req_grant_i,
  input  logic                                  rsp_valid_i,
  input  logic [TID_W-1:0]                      rsp_tid_i,
  input  logic [TAG_W-1:0]                      rsp_tag_i,
  input  logic                                  retry_i,
  output logic [NUM_THREADS-1:0][3:0]           status_o,
  output logic [NUM_THREADS-1:0][NUM_STAGES-1:0] stall_bits_o,
  output logic [NUM_THREADS-1:0][TAG_W-1:0]     req_tag_o,
  output logic                                  cache_blocked_o,
  output logic                                  retry_valid_o,
  output logic [TID_W-1:0]                      retry_tid_o,
  output logic [CNT_W-1:0]                      drop_cnt_o,
  output logic                                  protocol_err_o
);
  logic [NUM_THREADS-1:0][NUM_STAGES-1:0] bits_next;
  logic [NUM_THREADS-1:0] kill_vec, refuse_vec, take_vec;

  fsc_stall_bits #(.NUM_THREADS(NUM_THREADS)) u_stall (
    .clk       (clk),
    .rst       (rst),
    .block_i   (block_i),
    .unblock_i (unblock_i),
    .bits_q    (stall_bits_o),
    .bits_next (bits_next),
    .err_q     (protocol_err_o)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fstat_e st;
    logic   stalled;
    assign stalled = (|bits_next[t]) | ctx_switch_i;

    fsc_thread_fsm #(.TAG_W(TAG_W)) u_fsm (
      .clk             (clk),
      .rst             (rst),
      .stalled_i       (stalled),
      .cmt_sq_i        (cmt_squash_i[t]),
      .rob_sq_i        (rob_squashing_i[t]),
      .dec_sq_i        (dec_squash_i[t]),
      .rsp_hit_i       (rsp_valid_i && rsp_tid_i == TID_W'(t)),
      .rsp_tag_i       (rsp_tag_i),
      .retry_own_i     (retry_i && retry_valid_o && retry_tid_o == TID_W'(t)),
      .req_i           (req_valid_i && req_tid_i == TID_W'(t)),
      .grant_i         (req_grant_i),
      .cache_blocked_i (cache_blocked_o),
      .state_o         (st),
      .tag_o           (req_tag_o[t]),
      .kill_o          (kill_vec[t]),
      .refuse_o        (refuse_vec[t]),
      .rsp_take_o      (take_vec[t])
    );
    assign status_o[t] = st;
  end

  fsc_retry_slot #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_slot (
    .clk          (clk),
    .rst          (rst),
    .refuse_vec_i (refuse_vec),
    .kill_vec_i   (kill_vec),
    .retry_i      (retry_i),
    .valid_o      (retry_valid_o),
    .tid_o        (retry_tid_o),
    .blocked_o    (cache_blocked_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_cnt_o <= '0;
    end else if (rsp_valid_i && !(|take_vec)) begin
      drop_cnt_o <= drop_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/fetch_status_ctl_chk.sv
`timescale 1ns/1ps
module fetch_status_ctl_chk
  import fsc_pkg::*;
#(
  parameter  int NUM_THREADS = 2,
  parameter  int TAG_W       = 3,
  parameter  int CNT_W       = 8,
  localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic [NUM_THREADS-1:0][NUM_STAGES-1:0] block_i,
  input logic [NUM_THREADS-1:0][NUM_STAGES-1:0] unblock_i,
  input logic [NUM_THREADS-1:0]                cmt_squash_i,
  input logic [NUM_THREADS-1:0]                rob_squashing_i,
  input logic [NUM_THREADS-1:0]                dec_squash_i,
  input logic                                  rsp_valid_i,
  input logic [TID_W-1:0]                      rsp_tid_i,
  input logic                                  retry_i,
  input logic [NUM_THREADS-1:0][3:0]           status_o,
  input logic [NUM_THREADS-1:0][NUM_STAGES-1:0] stall_bits_o,
  input logic [NUM_THREADS-1:0][TAG_W-1:0]     req_tag_o,
  input logic                                  cache_blocked_o,
  input logic [CNT_W-1:0]                      drop_cnt_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_t
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_s
      p_block_sets_r1: assert property (@(posedge clk) disable iff (rst)
        block_i[t][s] |=> stall_bits_o[t][s]);
      p_unblock_clears_r1: assert property (@(posedge clk) disable iff (rst)
        (unblock_i[t][s] && !block_i[t][s]) |=> !stall_bits_o[t][s]);
    end

    p_commit_squash_r3: assert property (@(posedge clk) disable iff (rst)
      cmt_squash_i[t] |=> (status_o[t] == ST_SQUASH));

    p_decode_squash_r4: assert property (@(posedge clk) disable iff (rst)
      (dec_squash_i[t] && !cmt_squash_i[t] && !rob_squashing_i[t] && status_o[t] != ST_SQUASH)
      |=> (status_o[t] == ST_SQUASH && req_tag_o[t] == TAG_W'($past(req_tag_o[t]) + 1'b1)));

    p_legal_state_r12: assert property (@(posedge clk) disable iff (rst)
      !(status_o[t] inside {ST_IDLE, ST_TRAP, ST_QUIESCE}) && status_o[t] <= ST_QUIESCE);
  end

  p_retry_unblocks_r10: assert property (@(posedge clk) disable iff (rst)
    (retry_i && cache_blocked_o) |=> !cache_blocked_o);

  p_stale_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_i && status_o[rsp_tid_i] != ST_WAIT_RSP)
    |=> (drop_cnt_o == CNT_W'($past(drop_cnt_o) + 1'b1)));
endmodule

bind fetch_status_ctl fetch_status_ctl_chk #(
  .NUM_THREADS(NUM_THREADS), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/fetch_status_ctl_tb.sv
`timescale 1ns/1ps
module fetch_status_ctl_tb;
  import fsc_pkg::*;
  localparam int NT = 2, TW = 3, CW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [NT-1:0][3:0] block_i, unblock_i;
  logic [NT-1:0] cmt_squash_i, rob_squashing_i, dec_squash_i;
  logic ctx_switch_i, req_valid_i, req_grant_i, rsp_valid_i, retry_i;
  logic [0:0] req_tid_i, rsp_tid_i, retry_tid_o;
  logic [TW-1:0] rsp_tag_i;
  logic [NT-1:0][3:0] status_o, stall_bits_o;
  logic [NT-1:0][TW-1:0] req_tag_o;
  logic cache_blocked_o, retry_valid_o, protocol_err_o;
  logic [CW-1:0] drop_cnt_o;

  int checks = 0, fails = 0, exp_drop = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_status_ctl #(.NUM_THREADS(NT), .TAG_W(TW), .CNT_W(CW)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    block_i = '0; unblock_i = '0; cmt_squash_i = '0; rob_squashing_i = '0;
    dec_squash_i = '0; ctx_switch_i = 0; req_valid_i = 0; req_tid_i = 0;
    req_grant_i = 0; rsp_valid_i = 0; rsp_tid_i = 0; rsp_tag_i = '0; retry_i = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); clr();
  endtask

  task automatic st(input int t, input fstat_e e, input string req);
    chk(status_o[t] == e, req, int'(status_o[t]), int'(e));
  endtask

  task automatic req(input int t, input bit g);
    req_valid_i = 1; req_tid_i = 1'(t); req_grant_i = g;
  endtask

  task automatic rsp(input int t, input int tag);
    rsp_valid_i = 1; rsp_tid_i = 1'(t); rsp_tag_i = TW'(tag);
  endtask

  task automatic t_reset();
    st(0, ST_RUN, "R12"); st(1, ST_RUN, "R12");
    chk(stall_bits_o == '0, "R12", int'(stall_bits_o), 0);
    chk(req_tag_o == '0 && drop_cnt_o == 0, "R12", int'(drop_cnt_o), 0);
    chk(!cache_blocked_o && !retry_valid_o, "R12", int'(cache_blocked_o), 0);
  endtask

  task automatic t_stall();
    block_i[0][2] = 1; step();
    chk(stall_bits_o[0] == 4'b0100, "R1", int'(stall_bits_o[0]), 4);
    st(0, ST_BLOCK, "R5");
    unblock_i[0][2] = 1; step();
    chk(stall_bits_o[0] == 4'b0000, "R1", int'(stall_bits_o[0]), 0);
    st(0, ST_RUN, "R6");
    unblock_i[1][0] = 1; step();
    chk(protocol_err_o == 1, "R2", int'(protocol_err_o), 1);
    chk(stall_bits_o[1] == 4'b0000, "R2", int'(stall_bits_o[1]), 0);
    st(1, ST_RUN, "R2");
    step();
    chk(protocol_err_o == 0, "R2", int'(protocol_err_o), 0);
    ctx_switch_i = 1; step();
    st(1, ST_BLOCK, "R5");
    step();
    st(1, ST_RUN, "R6");
  endtask

  task automatic t_req_rsp();
    req(0, 1); step();
    st(0, ST_WAIT_RSP, "R7");
    block_i[0][0] = 1; step();
    st(0, ST_WAIT_RSP, "R5");
    rsp(0, 0); step();
    st(0, ST_BLOCK, "R9");
    chk(drop_cnt_o == CW'(exp_drop), "R8", int'(drop_cnt_o), exp_drop);
    unblock_i[0][0] = 1; step();
    st(0, ST_RUN, "R6");
    req(0, 1); step();
    rsp(0, 1); step(); exp_drop++;
    chk(drop_cnt_o == CW'(exp_drop), "R8", int'(drop_cnt_o), exp_drop);
    st(0, ST_WAIT_RSP, "R8");
    rsp(0, 0); step();
    st(0, ST_LINE_READY, "R9");
    req(0, 1); step();
    st(0, ST_RUN, "R7");
    rsp(0, 0); step(); exp_drop++;
    chk(drop_cnt_o == CW'(exp_drop), "R8", int'(drop_cnt_o), exp_drop);
  endtask

  task automatic t_squash();
    req(0, 1); step();
    cmt_squash_i[0] = 1; dec_squash_i[0] = 1; rsp(0, 0); step(); exp_drop++;
    st(0, ST_SQUASH, "R3");
    chk(req_tag_o[0] == 1, "R3", int'(req_tag_o[0]), 1);
    chk(drop_cnt_o == CW'(exp_drop), "R8", int'(drop_cnt_o), exp_drop);
    step();
    st(0, ST_RUN, "R6");
    rob_squashing_i[0] = 1; step();
    st(0, ST_SQUASH, "R3");
    chk(req_tag_o[0] == 1, "R3", int'(req_tag_o[0]), 1);
    dec_squash_i[0] = 1; step();
    st(0, ST_RUN, "R4");
    chk(req_tag_o[0] == 1, "R4", int'(req_tag_o[0]), 1);
    dec_squash_i[0] = 1; step();
    st(0, ST_SQUASH, "R4");
    chk(req_tag_o[0] == 2, "R4", int'(req_tag_o[0]), 2);
    step();
  endtask

  task automatic t_retry();
    req(0, 0); step();
    st(0, ST_WAIT_RETRY, "R10");
    chk(cache_blocked_o && retry_valid_o && retry_tid_o == 0, "R10", int'(retry_valid_o), 1);
    req(1, 1); step();
    st(1, ST_RUN, "R7");
    retry_i = 1; step();
    st(0, ST_WAIT_RSP, "R10");
    chk(!cache_blocked_o && !retry_valid_o, "R10", int'(cache_blocked_o), 0);
    rsp(0, 2); step();
    st(0, ST_LINE_READY, "R9");
    req(0, 1); step();
    req(1, 0); step();
    chk(retry_valid_o && retry_tid_o == 1, "R10", int'(retry_tid_o), 1);
    cmt_squash_i[1] = 1; step();
    chk(!retry_valid_o && !cache_blocked_o, "R11", int'(retry_valid_o), 0);
    st(1, ST_SQUASH, "R11");
    step();
    req(0, 0); step();
    dec_squash_i[1] = 1; step();
    chk(retry_valid_o && cache_blocked_o, "R11", int'(retry_valid_o), 1);
    st(0, ST_WAIT_RETRY, "R11");
    step();
    retry_i = 1; step();
    st(0, ST_WAIT_RSP, "R10");
    retry_i = 1; step();
    chk(!cache_blocked_o && !retry_valid_o, "R10", int'(cache_blocked_o), 0);
    st(0, ST_WAIT_RSP, "R10");
    st(1, ST_RUN, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_stall();
    t_req_rsp();
    t_squash();
    t_retry();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule